// File: doc/BRIEF.md
# PLL Rate Table Rounding Search

This block holds a small register table of supported PLL output rates, each stored with the three divider settings that produce it: input divider, feedback multiplier and output divider. A query starts with a one-cycle `start` pulse. The query carries a requested rate, the parent reference rate and a mode bit. The block then walks the table one entry per clock. When it reaches a decision, it raises `done` for one cycle and presents the result on its outputs.

Round mode returns the rate the PLL can actually reach. When the request is at or below the parent rate, the answer is the parent rate, because only bypass can give that. Otherwise the answer is the first table entry at or below the request. The table is kept in descending order, and when every entry is above the request the answer is the smallest entry. Exact mode looks for an entry whose rate equals the request. It returns that entry's divider triple, or raises a not-found flag when there is none. A zero rate marks the end of the table.

The table is loaded through a simple write port while no query is running. The divider values are stored exactly as written. The block does no arithmetic on them.

Top module: `pll_rate_seek`

## Requirements
- R1: In round mode (`mode`=0), when `req_rate` is less than or equal to `parent_rate`, `res_rate` equals `parent_rate`. The result is given one cycle after the start, whatever the table holds.
- R2: In round mode, when the request is above the parent rate, `res_rate` is the rate of the lowest-index entry whose rate is less than or equal to the request. An entry at index i is decided i+1 cycles after the start.
- R3: In round mode, when every valid entry is above the request, `res_rate` is the rate of the last valid entry.
- R4: The valid length is the number of entries before the first entry whose rate is zero. Entries at or after that zero are never matched and never used as the fallback. A table with no zero entry is decided by the last index at the latest.
- R5: In exact mode (`mode`=1), the result for the lowest-index valid entry whose rate equals the request carries that entry's rate and divider triple, with `res_invalid`=0. Round-mode results always carry zero dividers.
- R6: In exact mode, when no valid entry equals the request, `res_invalid`=1 and the rate and dividers are zero.
- R7: In round mode, with an empty table and a request above the parent rate, `res_empty`=1 and `res_rate`=0 one cycle after the start. `res_empty` and `res_invalid` are never both set.
- R8: `busy` rises the cycle after an accepted start and stays high until the cycle `done` is high. `done` is high for exactly one cycle per query. The results hold their values until the next `done`.
- R9: A `start` that arrives while `busy` is high is ignored. It neither changes the running query nor causes an extra `done`.
- R10: A table write while `busy` is high is dropped. A write while idle takes effect for the next query.
- R11: After reset, `busy`, `done`, the result flags and the result fields are all zero, and every table entry reads as rate zero, so the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | IDX_W | Table entry index to write |
| tbl_rate | input | RATE_W | Rate to store, Hz; 0 marks the end of the table |
| tbl_idiv | input | IDIV_W | Input divider setting to store |
| tbl_fmul | input | FMUL_W | Feedback multiplier setting to store |
| tbl_odiv | input | ODIV_W | Output divider setting to store |
| start | input | 1 | One-cycle query request |
| mode | input | 1 | 0 = round search, 1 = exact lookup |
| req_rate | input | RATE_W | Requested rate, Hz |
| parent_rate | input | RATE_W | Parent reference rate, Hz |
| busy | output | 1 | Query in progress |
| done | output | 1 | One-cycle result strobe |
| res_rate | output | RATE_W | Resulting rate |
| res_idiv | output | IDIV_W | Input divider of the exact hit |
| res_fmul | output | FMUL_W | Feedback multiplier of the exact hit |
| res_odiv | output | ODIV_W | Output divider of the exact hit |
| res_invalid | output | 1 | Exact lookup found no match |
| res_empty | output | 1 | Round search over an empty table |

## Verification
Most internal faults in this block show up at the very next `done` pulse. An index that skips or sticks moves the pulse to the wrong cycle and reports a neighbouring entry's rate. The cycle of the pulse therefore counts as a result just like the rate, and the bench checks both. A stale fallback register only shows when a round search runs off the end of the valid entries, so the sweeps request rates below every entry, both with a zero terminator and with a full table. A table entry corrupted by a write during a scan stays hidden until a later exact lookup targets that entry, so the bench issues that lookup straight after the busy window.

// File: rtl/pll_seek_pkg.sv
// Package: shared encodings for the PLL rate table search.
// Assumes: nothing; holds only type definitions.
package pll_seek_pkg;

    // Query mode as driven on the top-level mode pin.
    typedef enum logic {
        MODE_ROUND = 1'b0,
        MODE_EXACT = 1'b1
    } seek_mode_e;

    // Controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } seek_state_e;

endpackage

// File: rtl/pll_rate_table.sv
// Module: register table of PLL rate entries with one write port and one
// combinational read port.
// Assumes: the caller gates the write strobe (writes are taken whenever
// wr_en is high); addresses at or above DEPTH are dropped; reset clears
// every entry to zero, which makes the table empty.
module pll_rate_table #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int RATE_W = 32,
    parameter int IDIV_W = 6,
    parameter int FMUL_W = 13,
    parameter int ODIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [RATE_W-1:0] wr_rate,
    input  logic [IDIV_W-1:0] wr_idiv,
    input  logic [FMUL_W-1:0] wr_fmul,
    input  logic [ODIV_W-1:0] wr_odiv,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [RATE_W-1:0] rd_rate,
    output logic [IDIV_W-1:0] rd_idiv,
    output logic [FMUL_W-1:0] rd_fmul,
    output logic [ODIV_W-1:0] rd_odiv
);

    logic [RATE_W-1:0] rate_arr [DEPTH];
    logic [IDIV_W-1:0] idiv_arr [DEPTH];
    logic [FMUL_W-1:0] fmul_arr [DEPTH];
    logic [ODIV_W-1:0] odiv_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic              sel;
        logic [RATE_W-1:0] rate_q;
        logic [IDIV_W-1:0] idiv_q;
        logic [FMUL_W-1:0] fmul_q;
        logic [ODIV_W-1:0] odiv_q;

        assign sel = wr_en && (wr_addr == IDX_W'(g));

        // Store one entry; reset clears it to the end-of-table marker.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rate_q <= '0;
                idiv_q <= '0;
                fmul_q <= '0;
                odiv_q <= '0;
            end else if (sel) begin
                rate_q <= wr_rate;
                idiv_q <= wr_idiv;
                fmul_q <= wr_fmul;
                odiv_q <= wr_odiv;
            end
        end

        assign rate_arr[g] = rate_q;
        assign idiv_arr[g] = idiv_q;
        assign fmul_arr[g] = fmul_q;
        assign odiv_arr[g] = odiv_q;
    end

    // Read port: out-of-range index reads as an end marker.
    always_comb begin
        rd_rate = '0;
        rd_idiv = '0;
        rd_fmul = '0;
        rd_odiv = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == IDX_W'(i)) begin
                rd_rate = rate_arr[i];
                rd_idiv = idiv_arr[i];
                rd_fmul = fmul_arr[i];
                rd_odiv = odiv_arr[i];
            end
        end
    end

endmodule

// File: rtl/pll_seek_cmp.sv
// Module: comparison unit for one scan step; judges the current entry
// against the captured request and parent rate.
// Assumes: unsigned rates; a zero entry rate is the table terminator.
module pll_seek_cmp #(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] req,
    input  logic [RATE_W-1:0] parent,
    input  logic [RATE_W-1:0] ent_rate,
    output logic              bypass,
    output logic              term,
    output logic              floor_hit,
    output logic              exact_hit
);

    // All four step conditions, evaluated in parallel.
    always_comb begin
        bypass    = (req <= parent);
        term      = (ent_rate == '0);
        floor_hit = (req >= ent_rate);
        exact_hit = (req == ent_rate);
    end

endmodule

// File: rtl/pll_seek_ctrl.sv
// Module: scan controller; walks the table one entry per cycle, decides
// the round or exact result and registers it with a one-cycle done strobe.
// Assumes: the table is sorted by descending rate up to its first zero
// entry; start is only honoured while idle.
module pll_seek_ctrl
    import pll_seek_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int RATE_W = 32,
    parameter int IDIV_W = 6,
    parameter int FMUL_W = 13,
    parameter int ODIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  seek_mode_e        mode,
    input  logic [RATE_W-1:0] req_rate,
    input  logic [RATE_W-1:0] parent_rate,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [RATE_W-1:0] ent_rate,
    input  logic [IDIV_W-1:0] ent_idiv,
    input  logic [FMUL_W-1:0] ent_fmul,
    input  logic [ODIV_W-1:0] ent_odiv,
    output logic              busy,
    output logic              done,
    output logic [RATE_W-1:0] res_rate,
    output logic [IDIV_W-1:0] res_idiv,
    output logic [FMUL_W-1:0] res_fmul,
    output logic [ODIV_W-1:0] res_odiv,
    output logic              res_invalid,
    output logic              res_empty,
    output logic [RATE_W-1:0] cap_req,
    output logic [RATE_W-1:0] cap_par,
    output seek_mode_e        cap_mode
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    seek_state_e       state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RATE_W-1:0] req_q;
    logic [RATE_W-1:0] par_q;
    seek_mode_e        mode_q;
    logic [RATE_W-1:0] last_rate_q;

    logic              bypass, term, floor_hit, exact_hit;
    logic              fin;
    logic [RATE_W-1:0] fin_rate;
    logic [IDIV_W-1:0] fin_idiv;
    logic [FMUL_W-1:0] fin_fmul;
    logic [ODIV_W-1:0] fin_odiv;
    logic              fin_inv;
    logic              fin_empty;

    logic              done_q;
    logic [RATE_W-1:0] rrate_q;
    logic [IDIV_W-1:0] ridiv_q;
    logic [FMUL_W-1:0] rfmul_q;
    logic [ODIV_W-1:0] rodiv_q;
    logic              rinv_q;
    logic              rempty_q;

    pll_seek_cmp #(.RATE_W(RATE_W)) u_cmp (
        .req       (req_q),
        .parent    (par_q),
        .ent_rate  (ent_rate),
        .bypass    (bypass),
        .term      (term),
        .floor_hit (floor_hit),
        .exact_hit (exact_hit)
    );

    // Decide whether the current step ends the query and with what result.
    always_comb begin
        fin       = 1'b0;
        fin_rate  = '0;
        fin_idiv  = '0;
        fin_fmul  = '0;
        fin_odiv  = '0;
        fin_inv   = 1'b0;
        fin_empty = 1'b0;
        if (mode_q == MODE_ROUND && bypass) begin
            fin      = 1'b1;
            fin_rate = par_q;
        end else if (term) begin
            fin = 1'b1;
            if (mode_q == MODE_ROUND) begin
                if (idx_q == '0) begin
                    fin_empty = 1'b1;
                end else begin
                    fin_rate = last_rate_q;
                end
            end else begin
                fin_inv = 1'b1;
            end
        end else if (mode_q == MODE_ROUND && floor_hit) begin
            fin      = 1'b1;
            fin_rate = ent_rate;
        end else if (mode_q == MODE_EXACT && exact_hit) begin
            fin      = 1'b1;
            fin_rate = ent_rate;
            fin_idiv = ent_idiv;
            fin_fmul = ent_fmul;
            fin_odiv = ent_odiv;
        end else if (idx_q == LAST_IDX) begin
            fin = 1'b1;
            if (mode_q == MODE_ROUND) begin
                fin_rate = ent_rate;
            end else begin
                fin_inv = 1'b1;
            end
        end
    end

    // Sequencer: capture on start, step the index, register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            req_q       <= '0;
            par_q       <= '0;
            mode_q      <= MODE_ROUND;
            last_rate_q <= '0;
            done_q      <= 1'b0;
            rrate_q     <= '0;
            ridiv_q     <= '0;
            rfmul_q     <= '0;
            rodiv_q     <= '0;
            rinv_q      <= 1'b0;
            rempty_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q     <= ST_SCAN;
                        idx_q       <= '0;
                        req_q       <= req_rate;
                        par_q       <= parent_rate;
                        mode_q      <= mode;
                        last_rate_q <= '0;
                    end
                end
                ST_SCAN: begin
                    if (fin) begin
                        state_q  <= ST_IDLE;
                        done_q   <= 1'b1;
                        rrate_q  <= fin_rate;
                        ridiv_q  <= fin_idiv;
                        rfmul_q  <= fin_fmul;
                        rodiv_q  <= fin_odiv;
                        rinv_q   <= fin_inv;
                        rempty_q <= fin_empty;
                    end else begin
                        idx_q       <= idx_q + 1'b1;
                        last_rate_q <= ent_rate;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_addr     = idx_q;
    assign busy        = (state_q == ST_SCAN);
    assign done        = done_q;
    assign res_rate    = rrate_q;
    assign res_idiv    = ridiv_q;
    assign res_fmul    = rfmul_q;
    assign res_odiv    = rodiv_q;
    assign res_invalid = rinv_q;
    assign res_empty   = rempty_q;
    assign cap_req     = req_q;
    assign cap_par     = par_q;
    assign cap_mode    = mode_q;

endmodule

// File: rtl/pll_rate_seek.sv
// Module: top of the PLL rate table search; joins the table store and the
// scan controller and blocks table writes during a query.
// Assumes: the table is loaded in descending rate order while idle.
module pll_rate_seek
    import pll_seek_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int RATE_W = 32,
    parameter int IDIV_W = 6,
    parameter int FMUL_W = 13,
    parameter int ODIV_W = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic [RATE_W-1:0] tbl_rate,
    input  logic [IDIV_W-1:0] tbl_idiv,
    input  logic [FMUL_W-1:0] tbl_fmul,
    input  logic [ODIV_W-1:0] tbl_odiv,
    input  logic              start,
    input  logic              mode,
    input  logic [RATE_W-1:0] req_rate,
    input  logic [RATE_W-1:0] parent_rate,
    output logic              busy,
    output logic              done,
    output logic [RATE_W-1:0] res_rate,
    output logic [IDIV_W-1:0] res_idiv,
    output logic [FMUL_W-1:0] res_fmul,
    output logic [ODIV_W-1:0] res_odiv,
    output logic              res_invalid,
    output logic              res_empty
);

    logic [IDX_W-1:0]  rd_addr;
    logic [RATE_W-1:0] ent_rate;
    logic [IDIV_W-1:0] ent_idiv;
    logic [FMUL_W-1:0] ent_fmul;
    logic [ODIV_W-1:0] ent_odiv;
    logic              wr_ok;
    logic [RATE_W-1:0] cap_req;
    logic [RATE_W-1:0] cap_par;
    seek_mode_e        cap_mode;

    // Table writes are only taken while no query runs.
    assign wr_ok = tbl_we && !busy;

    pll_rate_table #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .RATE_W(RATE_W),
        .IDIV_W(IDIV_W), .FMUL_W(FMUL_W), .ODIV_W(ODIV_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_addr (tbl_addr),
        .wr_rate (tbl_rate),
        .wr_idiv (tbl_idiv),
        .wr_fmul (tbl_fmul),
        .wr_odiv (tbl_odiv),
        .rd_addr (rd_addr),
        .rd_rate (ent_rate),
        .rd_idiv (ent_idiv),
        .rd_fmul (ent_fmul),
        .rd_odiv (ent_odiv)
    );

    pll_seek_ctrl #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .RATE_W(RATE_W),
        .IDIV_W(IDIV_W), .FMUL_W(FMUL_W), .ODIV_W(ODIV_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (seek_mode_e'(mode)),
        .req_rate    (req_rate),
        .parent_rate (parent_rate),
        .rd_addr     (rd_addr),
        .ent_rate    (ent_rate),
        .ent_idiv    (ent_idiv),
        .ent_fmul    (ent_fmul),
        .ent_odiv    (ent_odiv),
        .busy        (busy),
        .done        (done),
        .res_rate    (res_rate),
        .res_idiv    (res_idiv),
        .res_fmul    (res_fmul),
        .res_odiv    (res_odiv),
        .res_invalid (res_invalid),
        .res_empty   (res_empty),
        .cap_req     (cap_req),
        .cap_par     (cap_par),
        .cap_mode    (cap_mode)
    );

endmodule

// File: rtl/pll_rate_seek_chk.sv
// Module: property checker for pll_rate_seek, bound into every instance.
// Assumes: synchronous active-low reset on rst_n.
module pll_rate_seek_chk
    import pll_seek_pkg::*;
#(
    parameter int RATE_W = 32,
    parameter int IDIV_W = 6,
    parameter int FMUL_W = 13,
    parameter int ODIV_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [RATE_W-1:0] res_rate,
    input logic [IDIV_W-1:0] res_idiv,
    input logic [FMUL_W-1:0] res_fmul,
    input logic [ODIV_W-1:0] res_odiv,
    input logic              res_invalid,
    input logic              res_empty,
    input logic [RATE_W-1:0] cap_req,
    input logic [RATE_W-1:0] cap_par,
    input seek_mode_e        cap_mode
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R8
    AST_DONE_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cap_req) && $stable(cap_par) && $stable(cap_mode))); // R9
    AST_BYPASS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_mode == MODE_ROUND && cap_req <= cap_par) |-> (res_rate == cap_par)); // R1
    AST_EXACT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_mode == MODE_EXACT && !res_invalid) |-> (res_rate == cap_req)); // R5
    AST_ROUND_NO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_mode == MODE_ROUND) |-> (res_idiv == '0 && res_fmul == '0 && res_odiv == '0)); // R5
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_invalid) |-> (cap_mode == MODE_EXACT && res_rate == '0)); // R6
    AST_EMPTY_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_empty) |-> (cap_mode == MODE_ROUND && res_rate == '0 && cap_req > cap_par)); // R7
    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_empty, res_invalid})); // R7

endmodule

bind pll_rate_seek pll_rate_seek_chk #(
    .RATE_W(RATE_W), .IDIV_W(IDIV_W), .FMUL_W(FMUL_W), .ODIV_W(ODIV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .res_rate    (res_rate),
    .res_idiv    (res_idiv),
    .res_fmul    (res_fmul),
    .res_odiv    (res_odiv),
    .res_invalid (res_invalid),
    .res_empty   (res_empty),
    .cap_req     (cap_req),
    .cap_par     (cap_par),
    .cap_mode    (cap_mode)
);

// File: tb/sim_pll_rate_seek.sv
// Bench: sweeps requests around every stored rate over several tables and
// compares against a rate model computed here from the requirements.
module sim_pll_rate_seek;

    localparam int DEPTH = 16;
    localparam int IW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [IW-1:0] tbl_addr = '0;
    logic [31:0] tbl_rate = '0;
    logic [5:0]  tbl_idiv = '0;
    logic [12:0] tbl_fmul = '0;
    logic [3:0]  tbl_odiv = '0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] req_rate = '0;
    logic [31:0] parent_rate = '0;
    logic        busy, done, res_invalid, res_empty;
    logic [31:0] res_rate;
    logic [5:0]  res_idiv;
    logic [12:0] res_fmul;
    logic [3:0]  res_odiv;

    always #2 clk = ~clk;

    pll_rate_seek u0 (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_rate(tbl_rate), .tbl_idiv(tbl_idiv), .tbl_fmul(tbl_fmul),
        .tbl_odiv(tbl_odiv), .start(start), .mode(mode), .req_rate(req_rate),
        .parent_rate(parent_rate), .busy(busy), .done(done),
        .res_rate(res_rate), .res_idiv(res_idiv), .res_fmul(res_fmul),
        .res_odiv(res_odiv), .res_invalid(res_invalid), .res_empty(res_empty)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] t_rate [DEPTH];
    logic [5:0]  t_idiv [DEPTH];
    logic [12:0] t_fmul [DEPTH];
    logic [3:0]  t_odiv [DEPTH];

    logic [31:0] e_rate;
    logic [5:0]  e_idiv;
    logic [12:0] e_fmul;
    logic [3:0]  e_odiv;
    logic        e_inv, e_empty;
    int          e_lat;
    string       e_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic put(input int i, input logic [31:0] r, input logic [5:0] a,
                       input logic [12:0] b, input logic [3:0] c);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = IW'(i); tbl_rate = r;
        tbl_idiv = a; tbl_fmul = b; tbl_odiv = c;
        @(negedge clk);
        tbl_we = 1'b0;
        t_rate[i] = r; t_idiv[i] = a; t_fmul[i] = b; t_odiv[i] = c;
    endtask

    // Expected result from the requirements.
    task automatic model(input bit m, input logic [31:0] rq, input logic [31:0] pr);
        int len = DEPTH;
        bit hit = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) if (t_rate[i] == 0) len = i;
        e_rate = 0; e_idiv = 0; e_fmul = 0; e_odiv = 0; e_inv = 0; e_empty = 0;
        if (!m) begin
            if (rq <= pr) begin
                e_rate = pr; e_lat = 1; e_tag = "R1";
            end else if (len == 0) begin
                e_empty = 1; e_lat = 1; e_tag = "R7";
            end else begin
                for (int i = 0; i < len; i++)
                    if (!hit && rq >= t_rate[i]) begin
                        hit = 1; e_rate = t_rate[i]; e_lat = i + 1; e_tag = "R2";
                    end
                if (!hit) begin
                    e_rate = t_rate[len-1]; e_tag = "R3";
                    e_lat = (len == DEPTH) ? DEPTH : len + 1;
                end
            end
        end else begin
            for (int i = 0; i < len; i++)
                if (!hit && rq == t_rate[i]) begin
                    hit = 1; e_rate = rq; e_idiv = t_idiv[i]; e_fmul = t_fmul[i];
                    e_odiv = t_odiv[i]; e_lat = i + 1; e_tag = "R5";
                end
            if (!hit) begin
                e_inv = 1; e_tag = "R6";
                e_lat = (len == DEPTH) ? DEPTH : len + 1;
            end
        end
    endtask

    task automatic query(input bit m, input logic [31:0] rq, input logic [31:0] pr,
                         input string force_tag);
        int lat = 0;
        int ndone = 0;
        logic [31:0] g_rate = 0;
        logic [5:0]  g_idiv = 0;
        logic [12:0] g_fmul = 0;
        logic [3:0]  g_odiv = 0;
        logic        g_inv = 0, g_empty = 0;
        model(m, rq, pr);
        if (force_tag != "") e_tag = force_tag;
        @(negedge clk);
        mode = m; req_rate = rq; parent_rate = pr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= DEPTH + 4; k++) begin
            @(negedge clk);
            if (done) begin
                ndone++;
                if (ndone == 1) begin
                    lat = k; g_rate = res_rate; g_idiv = res_idiv; g_fmul = res_fmul;
                    g_odiv = res_odiv; g_inv = res_invalid; g_empty = res_empty;
                    chk(!busy, "R8", "busy at done", busy, 0);
                end
            end else if (ndone == 0 && !busy) begin
                chk(0, "R8", "busy dropped early", k, e_lat);
            end
        end
        chk(ndone == 1, "R8", "done pulses", ndone, 1);
        chk(lat == e_lat, e_tag, "latency", lat, e_lat);
        chk(g_rate == e_rate, e_tag, "rate", g_rate, e_rate);
        chk({g_idiv, g_fmul, g_odiv} == {e_idiv, e_fmul, e_odiv}, e_tag, "dividers",
            {g_idiv, g_fmul, g_odiv}, {e_idiv, e_fmul, e_odiv});
        chk(g_inv == e_inv && g_empty == e_empty, e_tag, "flags",
            {g_inv, g_empty}, {e_inv, e_empty});
        chk(res_rate == g_rate, "R8", "result held", res_rate, g_rate);
    endtask

    task automatic sweep();
        logic [31:0] pars [2] = '{32'd10_000_000, 32'd300_000_000};
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 2; m++) begin
                for (int i = 0; i < DEPTH; i++) begin
                    query(m[0], t_rate[i], pars[p], "");
                    query(m[0], t_rate[i] + 1, pars[p], "");
                    query(m[0], t_rate[i] - 1, pars[p], "");
                end
                query(m[0], 32'd0, pars[p], "");
                query(m[0], 32'hFFFF_FFFF, pars[p], "");
            end
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int ndone;
        for (int i = 0; i < DEPTH; i++) begin
            t_rate[i] = 0; t_idiv[i] = 0; t_fmul[i] = 0; t_odiv[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!busy && !done, "R11", "busy/done after reset", {busy, done}, 0);
        chk(res_rate == 0 && !res_invalid && !res_empty, "R11", "results after reset",
            res_rate, 0);
        query(1'b0, 32'd100_000_000, 32'd10_000_000, "R11");
        query(1'b0, 32'd5_000_000, 32'd10_000_000, "R1");
        query(1'b1, 32'd100_000_000, 32'd10_000_000, "R6");

        // Table A: full, no terminator.
        for (int k = 0; k < DEPTH; k++)
            put(k, 32'(1600_000_000 - k * 100_000_000), 6'(k + 1), 13'(k * 3 + 7),
                4'(k % 4 + 1));
        sweep();

        // R9/R10: start and table write during a scan.
        @(negedge clk);
        mode = 1'b0; req_rate = 32'd150_000_000; parent_rate = 32'd50_000_000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; mode = 1'b1; req_rate = 32'd1600_000_000;
        tbl_we = 1'b1; tbl_addr = '0; tbl_rate = 32'd5; tbl_idiv = 6'd9;
        tbl_fmul = 13'd99; tbl_odiv = 4'd9;
        @(negedge clk);
        start = 1'b0; tbl_we = 1'b0;
        ndone = 0;
        for (int k = 0; k < DEPTH + 6; k++) begin
            @(negedge clk);
            if (done) begin
                ndone++;
                chk(res_rate == 32'd100_000_000 && !res_invalid, "R9", "busy start result",
                    res_rate, 100_000_000);
            end
        end
        chk(ndone == 1, "R9", "done count with busy start", ndone, 1);
        query(1'b1, 32'd1600_000_000, 32'd10_000_000, "R10");
        query(1'b1, 32'd5, 32'd10_000_000, "R10");

        // Table B: five valid entries, terminator, stale entries beyond.
        put(0, 32'd1188_000_000, 6'd2, 13'd99, 4'd1);
        put(1, 32'd1008_000_000, 6'd1, 13'd42, 4'd1);
        put(2, 32'd816_000_000, 6'd1, 13'd68, 4'd2);
        put(3, 32'd600_000_000, 6'd1, 13'd50, 4'd2);
        put(4, 32'd312_000_000, 6'd1, 13'd52, 4'd4);
        put(5, 32'd0, 6'd0, 13'd0, 4'd0);
        for (int k = 6; k < DEPTH; k++)
            put(k, 32'(200_000_000 - (k - 6) * 10_000_000), 6'(k), 13'(k), 4'(k));
        query(1'b1, 32'd200_000_000, 32'd10_000_000, "R4");
        query(1'b0, 32'd200_000_000, 32'd10_000_000, "R4");
        sweep();

        // Table C: single entry, stale entry after terminator.
        for (int k = 0; k < DEPTH; k++) put(k, 32'd0, 6'd0, 13'd0, 4'd0);
        put(0, 32'd24_000_000, 6'd3, 13'd17, 4'd5);
        put(3, 32'd900_000_000, 6'd1, 13'd1, 4'd1);
        query(1'b1, 32'd900_000_000, 32'd10_000_000, "R4");
        query(1'b0, 32'd20_000_000, 32'd10_000_000, "R3");
        sweep();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule